// File: doc/BRIEF.md
# System Control and I/O Register Decoder

This block sits behind the main CPU's system control window and turns each access into one of a handful of actions. Address bits 15:8 pick a page. Page 0x00 reaches the external I/O chip through a small strobed port. Page 0x11 holds the request bit for the secondary bus, and reads on that page report whether the bus is granted. Page 0x12 holds the reset bit for the secondary CPU. Page 0x41 holds the bit that chooses whether the low memory bank shows the cartridge or the boot ROM. A few more pages are accepted and do nothing. Any other page is a trap: the block raises a halt request, which stays set until reset.

Requests come in on a valid/ready channel. One request is accepted on each clock edge where `req_valid` and `req_ready` are both high. A write finishes when it is accepted. A read produces a response one cycle later on `rsp_valid`/`rsp_data`. That response stays on the pins until `rsp_ready` is seen high, and `req_ready` stays low while an unconsumed response is waiting. After a trap, `req_ready` stays low.

Lane rules:
- Byte writes carry their byte in `req_wdata[7:0]`.
- Byte reads return their byte in `rsp_data[7:0]`, and the upper byte is zero.
- Open-bus data comes from `open_bus`, the value the CPU side would otherwise see. For a byte access the even address takes `open_bus[15:8]` and the odd address takes `open_bus[7:0]`.

Top module: `ctl_io_decoder`

## Requirements
- R1: After reset, `busreq`, `sub_reset`, `map_cart`, `halt_req`, `rsp_valid` and `io_stb` are 0, and `req_ready` is 1.
- R2: A read on page 0x00 with address bits 7:5 zero strobes the I/O port with `io_we`=0 and `io_idx` = address bits 4:1. A byte read returns `io_rdata`. A word read returns `io_rdata` on both bytes.
- R3: On page 0x00, an address with any of bits 7:5 set never strobes the I/O port, and a read there returns open-bus data.
- R4: An I/O write strobes the port with `io_we`=1 and `io_wdata` = `req_wdata[7:0]`. For a byte write this happens only when (address & 0xE1) == 0x01. For a word write it happens only when bits 7:5 are zero.
- R5: Page 0x11 sets `busreq` from data bit 0 on an even byte write, or from data bit 8 on a word write. An odd byte write leaves it unchanged. The new value shows on the cycle after acceptance.
- R6: A read on page 0x11 puts NOT `bus_granted` into bit 0 of an even byte read, or into bit 8 of a word read. Every other bit, and the whole of an odd byte read, comes from open-bus data.
- R7: Page 0x12 drives `sub_reset` under the same even-byte bit 0 / word bit 8 rule as R5. Reads on page 0x12 return open bus.
- R8: Page 0x41 sets `map_cart` from data bit 0 on an odd byte write or on a word write, where 1 means cartridge and 0 means boot ROM. An even byte write is ignored. Reads return open bus.
- R9: Pages 0x10, 0x20, 0x40, 0x44 and 0x50 return open bus on reads and change no output on writes.
- R10: An access to any other page sets `halt_req` on the next cycle, and it then holds until reset. `req_ready` is 0 while `halt_req` is 1. A trapped read returns all ones (0xFFFF for a word, 0x00FF for a byte).
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` and `rsp_valid` hold, and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 16 | Offset inside the control window |
| req_wdata | input | 16 | Write data (byte writes in bits 7:0) |
| open_bus | input | 16 | Open-bus data for unmapped bits |
| bus_granted | input | 1 | Secondary bus is granted to the main CPU |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Read response taken this cycle |
| rsp_data | output | 16 | Read response data |
| io_stb | output | 1 | I/O chip access strobe (one per accepted access) |
| io_we | output | 1 | I/O chip access is a write |
| io_idx | output | 4 | I/O chip register index |
| io_wdata | output | 8 | I/O chip write byte |
| io_rdata | input | 8 | I/O chip read byte, valid in the strobe cycle |
| busreq | output | 1 | Secondary bus request |
| sub_reset | output | 1 | Secondary CPU reset control |
| map_cart | output | 1 | Low bank shows cartridge (1) or boot ROM (0) |
| halt_req | output | 1 | Sticky lockup/halt request |

## Verification
The assertions assume that a requester holds its request fields steady while `req_valid` is high, and that `io_rdata`, `open_bus` and `bus_granted` are settled in the cycle a read is accepted. The bench changes stimulus only on the falling clock edge and drops `req_valid` once a request is taken, so each request is accepted exactly once. Random page choices are drawn only from the mapped and silent pages, so the sticky trap is not hit before its own directed tests at the end, which come after a fresh reset. `rsp_ready` is low only in one directed back-pressure case; the rest of the run takes every response at once.

// File: rtl/ctl_io_pkg.sv
package ctl_io_pkg;

  typedef enum logic [2:0] {
    PG_IO    = 3'd0,
    PG_BREQ  = 3'd1,
    PG_SRST  = 3'd2,
    PG_OVL   = 3'd3,
    PG_QUIET = 3'd4,
    PG_TRAP  = 3'd5
  } page_kind_e;

  localparam int unsigned QUIET_N = 5;
  localparam logic [QUIET_N*8-1:0] QUIET_PAGES = {8'h10, 8'h20, 8'h40, 8'h44, 8'h50};

  function automatic logic is_quiet(input logic [7:0] pg);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < QUIET_N; i++) begin
      if (pg == QUIET_PAGES[i*8 +: 8]) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/ctl_page_decode.sv
module ctl_page_decode
  import ctl_io_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PAGE_LSB = 8,
  parameter int unsigned IDX_W    = 4,
  parameter logic [7:0]  P_IO     = 8'h00,
  parameter logic [7:0]  P_BREQ   = 8'h11,
  parameter logic [7:0]  P_SRST   = 8'h12,
  parameter logic [7:0]  P_OVL    = 8'h41
) (
  input  logic [ADDR_W-1:0] addr,
  output page_kind_e        kind,
  output logic              io_window,
  output logic [IDX_W-1:0]  io_idx
);
  localparam int unsigned WIN_LSB = IDX_W + 1;

  logic [7:0] page;
  assign page = addr[PAGE_LSB +: 8];

  always_comb begin
    if (page == P_IO)          kind = PG_IO;
    else if (page == P_BREQ)   kind = PG_BREQ;
    else if (page == P_SRST)   kind = PG_SRST;
    else if (page == P_OVL)    kind = PG_OVL;
    else if (is_quiet(page))   kind = PG_QUIET;
    else                       kind = PG_TRAP;
  end

  // bits above the index but below the page select the open-bus hole
  assign io_window = (addr[PAGE_LSB-1:WIN_LSB] == '0);
  assign io_idx    = addr[IDX_W:1];
endmodule

// File: rtl/ctl_ctrl_regs.sv
module ctl_ctrl_regs
  import ctl_io_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              trap_fire,
  input  page_kind_e        kind,
  input  logic              is_word,
  input  logic              odd,
  input  logic [DATA_W-1:0] wdata,
  output logic              busreq,
  output logic              sub_reset,
  output logic              map_cart,
  output logic              halt_req
);
  localparam int unsigned BYTE_W = DATA_W / 2;
  localparam int unsigned NCTL   = 2;

  logic [NCTL-1:0] ctl_q;

  // even byte writes take bit 0, word writes take bit 0 of the upper lane
  generate
    for (genvar g = 0; g < NCTL; g++) begin : g_ctl
      localparam page_kind_e SEL = (g == 0) ? PG_BREQ : PG_SRST;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ctl_q[g] <= 1'b0;
        end else if (wr_fire && kind == SEL) begin
          if (is_word)   ctl_q[g] <= wdata[BYTE_W];
          else if (!odd) ctl_q[g] <= wdata[0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_cart <= 1'b0;
    end else if (wr_fire && kind == PG_OVL && (is_word || odd)) begin
      map_cart <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         halt_req <= 1'b0;
    else if (trap_fire) halt_req <= 1'b1;
  end

  assign busreq    = ctl_q[0];
  assign sub_reset = ctl_q[1];
endmodule

// File: rtl/ctl_read_fmt.sv
module ctl_read_fmt
  import ctl_io_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  page_kind_e              kind,
  input  logic                    io_window,
  input  logic                    is_word,
  input  logic                    odd,
  input  logic [DATA_W-1:0]       open_bus,
  input  logic [DATA_W/2-1:0]     io_rdata,
  input  logic                    bus_granted,
  output logic [DATA_W-1:0]       rdata
);
  localparam int unsigned BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] ob_byte;
  logic              ack_n;

  assign ob_byte = odd ? open_bus[BYTE_W-1:0] : open_bus[DATA_W-1:BYTE_W];
  assign ack_n   = ~bus_granted;

  always_comb begin
    rdata = is_word ? open_bus : {{BYTE_W{1'b0}}, ob_byte};
    unique case (kind)
      PG_IO: begin
        if (io_window)
          rdata = is_word ? {io_rdata, io_rdata} : {{BYTE_W{1'b0}}, io_rdata};
      end
      PG_BREQ: begin
        if (is_word)
          rdata = {open_bus[DATA_W-1:BYTE_W+1], ack_n, open_bus[BYTE_W-1:0]};
        else if (!odd)
          rdata = {{BYTE_W{1'b0}}, open_bus[DATA_W-1:BYTE_W+1], ack_n};
      end
      PG_TRAP: rdata = is_word ? {DATA_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
      default: ;
    endcase
  end
endmodule

// File: rtl/ctl_io_decoder.sv
module ctl_io_decoder
  import ctl_io_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned PAGE_LSB = 8,
  parameter logic [7:0]  P_IO     = 8'h00,
  parameter logic [7:0]  P_BREQ   = 8'h11,
  parameter logic [7:0]  P_SRST   = 8'h12,
  parameter logic [7:0]  P_OVL    = 8'h41
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_word,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W-1:0]     open_bus,
  input  logic                  bus_granted,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  io_stb,
  output logic                  io_we,
  output logic [IDX_W-1:0]      io_idx,
  output logic [DATA_W/2-1:0]   io_wdata,
  input  logic [DATA_W/2-1:0]   io_rdata,
  output logic                  busreq,
  output logic                  sub_reset,
  output logic                  map_cart,
  output logic                  halt_req
);
  localparam int unsigned BYTE_W = DATA_W / 2;

  page_kind_e        kind;
  logic              io_window;
  logic              fire, wr_fire, rd_fire, trap_fire;
  logic              odd;
  logic [DATA_W-1:0] rdata;

  ctl_page_decode #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .IDX_W(IDX_W),
    .P_IO(P_IO), .P_BREQ(P_BREQ), .P_SRST(P_SRST), .P_OVL(P_OVL)
  ) i_dec (
    .addr(req_addr), .kind(kind), .io_window(io_window), .io_idx(io_idx)
  );

  assign odd       = req_addr[0];
  assign req_ready = !halt_req && (!rsp_valid || rsp_ready);
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;
  assign trap_fire = fire && (kind == PG_TRAP);

  // byte writes reach the I/O chip on the odd lane only
  assign io_stb   = fire && (kind == PG_IO) && io_window && (!req_write || req_word || odd);
  assign io_we    = req_write;
  assign io_wdata = req_wdata[BYTE_W-1:0];

  ctl_ctrl_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .trap_fire(trap_fire),
    .kind(kind), .is_word(req_word), .odd(odd), .wdata(req_wdata),
    .busreq(busreq), .sub_reset(sub_reset), .map_cart(map_cart), .halt_req(halt_req)
  );

  ctl_read_fmt #(.DATA_W(DATA_W)) i_fmt (
    .kind(kind), .io_window(io_window), .is_word(req_word), .odd(odd),
    .open_bus(open_bus), .io_rdata(io_rdata), .bus_granted(bus_granted),
    .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_io_decoder_chk.sv
module ctl_io_decoder_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_word,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              io_stb,
  input logic              io_we,
  input logic              busreq,
  input logic              map_cart,
  input logic              halt_req
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> halt_req);

  a_r10_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !req_ready);

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r3_io_window: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb |-> (req_addr[15:8] == 8'h00 && req_addr[7:5] == 3'b000));

  a_r4_io_byte_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (io_stb && io_we && !req_word) |-> req_addr[0]);

  a_r5_busreq_even: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !req_word && req_addr[15:8] == 8'h11 && !req_addr[0])
      |=> (busreq == $past(req_wdata[0])));

  a_r8_ovl_word: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_word && req_addr[15:8] == 8'h41)
      |=> (map_cart == $past(req_wdata[0])));

  a_r10_trap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_addr[15:8] == 8'h30) |=> halt_req);
endmodule

bind ctl_io_decoder ctl_io_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .io_stb(io_stb), .io_we(io_we), .busreq(busreq),
  .map_cart(map_cart), .halt_req(halt_req)
);

// File: tb/test_ctl_io_decoder.sv
`timescale 1ns/1ps
module test_ctl_io_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, open_bus = '0;
  logic        bus_granted = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  io_rdata = '0;
  logic        req_ready, rsp_valid, io_stb, io_we, busreq, sub_reset, map_cart, halt_req;
  logic [15:0] rsp_data;
  logic [3:0]  io_idx;
  logic [7:0]  io_wdata;

  int total = 0, bad = 0;
  bit m_breq, m_srst, m_ovl, m_halt;

  always #2.5 clk = ~clk;

  ctl_io_decoder i_ctl_io_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .open_bus(open_bus), .bus_granted(bus_granted),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .io_stb(io_stb), .io_we(io_we), .io_idx(io_idx), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .busreq(busreq), .sub_reset(sub_reset),
    .map_cart(map_cart), .halt_req(halt_req)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic bit is_quiet_pg(input logic [7:0] pg);
    return pg == 8'h10 || pg == 8'h20 || pg == 8'h40 || pg == 8'h44 || pg == 8'h50;
  endfunction

  function automatic bit is_trap_pg(input logic [7:0] pg);
    return !(pg == 8'h00 || pg == 8'h11 || pg == 8'h12 || pg == 8'h41 || is_quiet_pg(pg));
  endfunction

  function automatic bit exp_stb(input bit wr, input bit wd, input logic [15:0] a);
    if (a[15:8] != 8'h00 || a[7:5] != 3'b000) return 1'b0;
    if (wr && !wd) return (a[7:0] & 8'hE1) == 8'h01;
    return 1'b1;
  endfunction

  function automatic logic [15:0] exp_read(input bit wd, input logic [15:0] a,
      input logic [15:0] ob, input logic [7:0] io, input bit gr);
    logic [7:0] obb;
    logic [7:0] pg;
    pg  = a[15:8];
    obb = a[0] ? ob[7:0] : ob[15:8];
    if (is_trap_pg(pg)) return wd ? 16'hFFFF : 16'h00FF;
    if (pg == 8'h00 && a[7:5] == 3'b000) return wd ? {io, io} : {8'h00, io};
    if (pg == 8'h11) begin
      if (wd) return {ob[15:9], ~gr, ob[7:0]};
      if (!a[0]) return {8'h00, ob[15:9], ~gr};
    end
    return wd ? ob : {8'h00, obb};
  endfunction

  task automatic model_write(input bit wd, input logic [15:0] a, input logic [15:0] d);
    case (a[15:8])
      8'h11: if (wd) m_breq = d[8]; else if (!a[0]) m_breq = d[0];
      8'h12: if (wd) m_srst = d[8]; else if (!a[0]) m_srst = d[0];
      8'h41: if (wd || a[0]) m_ovl = d[0];
      default: ;
    endcase
  endtask

  function automatic string reqtag(input logic [15:0] a, input bit wr);
    case (a[15:8])
      8'h00: return (a[7:5] != 0) ? "R3" : (wr ? "R4" : "R2");
      8'h11: return wr ? "R5" : "R6";
      8'h12: return "R7";
      8'h41: return "R8";
      default: return is_trap_pg(a[15:8]) ? "R10" : "R9";
    endcase
  endfunction

  task automatic check_regs(input string tag);
    check({tag, " busreq"}, busreq, m_breq);
    check({tag, " sub_reset"}, sub_reset, m_srst);
    check({tag, " map_cart"}, map_cart, m_ovl);
    check({tag, " halt_req"}, halt_req, m_halt);
  endtask

  // called at a falling edge; returns at the following falling edge
  task automatic txn(input bit wr, input bit wd, input logic [15:0] a, input logic [15:0] d);
    string tg;
    logic [15:0] expd;
    bit st;
    tg = reqtag(a, wr);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    open_bus = 16'($urandom); io_rdata = 8'($urandom); bus_granted = 1'($urandom);
    #1;
    check({tag_s(tg), " req_ready"}, req_ready, 1'b1);
    st = exp_stb(wr, wd, a);
    check({tg, " io_stb"}, io_stb, st);
    if (st) begin
      check({tg, " io_we"}, io_we, wr);
      check({tg, " io_idx"}, io_idx, a[4:1]);
      if (wr) check({tg, " io_wdata"}, io_wdata, d[7:0]);
    end
    expd = exp_read(wd, a, open_bus, io_rdata, bus_granted);
    @(posedge clk);
    if (wr) model_write(wd, a, d);
    if (is_trap_pg(a[15:8])) m_halt = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      check({tg, " rsp_valid"}, rsp_valid, 1'b1);
      check({tg, " rsp_data"}, rsp_data, expd);
    end
    check_regs(tg);
  endtask

  function automatic string tag_s(input string t);
    return (t == "R10") ? "R10" : "R11";
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] pages [9];
    logic [15:0] held;
    void'($urandom(32'd1234));
    pages = '{8'h00, 8'h11, 8'h12, 8'h41, 8'h10, 8'h20, 8'h40, 8'h44, 8'h50};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 busreq", busreq, 0);   check("R1 sub_reset", sub_reset, 0);
    check("R1 map_cart", map_cart, 0); check("R1 halt_req", halt_req, 0);
    check("R1 rsp_valid", rsp_valid, 0); check("R1 io_stb", io_stb, 0);
    check("R1 req_ready", req_ready, 1);
    @(negedge clk);

    // directed corner cases
    txn(1, 0, 16'h0003, 16'h005A);  // R4 odd byte write reaches I/O
    txn(1, 0, 16'h0002, 16'h005A);  // R4 even byte write blocked
    txn(1, 0, 16'h0023, 16'h0011);  // R3 hole, no strobe
    txn(0, 1, 16'h0008, 16'h0000);  // R2 word read duplicated
    txn(0, 0, 16'h00E0, 16'h0000);  // R3 hole read
    txn(1, 0, 16'h1100, 16'h0001);  // R5 even byte sets
    txn(1, 0, 16'h1101, 16'h0000);  // R5 odd byte ignored
    txn(1, 1, 16'h1100, 16'h0001);  // R5 word uses bit 8 -> 0
    txn(1, 1, 16'h1200, 16'h0100);  // R7 word sets
    txn(0, 0, 16'h1100, 16'h0000);  // R6 even byte ack
    txn(0, 0, 16'h1101, 16'h0000);  // R6 odd byte open bus
    txn(1, 0, 16'h4100, 16'h0001);  // R8 even ignored
    txn(1, 0, 16'h4101, 16'h0001);  // R8 odd sets cart
    txn(1, 1, 16'h5000, 16'hFFFF);  // R9 silent write
    txn(0, 1, 16'h4400, 16'h0000);  // R9 silent read

    // random mix over mapped and silent pages
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a[15:8] = pages[$urandom_range(0, 8)];
      a[7:0]  = 8'($urandom);
      if (a[15:8] == 8'h00 && $urandom_range(0, 1) == 0) a[7:5] = 3'b000;
      txn(1'($urandom), 1'($urandom), a, 16'($urandom));
    end

    // R11: back-pressure on the response
    rsp_ready = 1'b0;
    txn(0, 1, 16'h0004, 16'h0000);
    held = rsp_data;
    check("R11 req_ready low", req_ready, 0);
    @(negedge clk);
    check("R11 rsp_valid held", rsp_valid, 1);
    check("R11 rsp_data held", rsp_data, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R11 rsp consumed", rsp_valid, 0);

    // R10: trap read, then reset, then trap write
    txn(0, 1, 16'h3000, 16'h0000);
    check("R10 req_ready after trap", req_ready, 0);
    repeat (2) @(negedge clk);
    check("R10 halt sticky", halt_req, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_breq = 0; m_srst = 0; m_ovl = 0; m_halt = 0;
    #1;
    check_regs("R1 after reset");
    @(negedge clk);
    txn(0, 0, 16'hAB01, 16'h0000);
    txn_blocked_check();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic txn_blocked_check();
    check("R10 blocked ready", req_ready, 0);
    check("R10 halt after byte trap", halt_req, 1);
  endtask
endmodule